// File: doc/BRIEF.md
# Frontbuffer Dirty Tracker with Deferred Re-arm

This block sits beside a display self-refresh controller and keeps a record of which display planes still have front-buffer rendering in progress. Rendering engines report the start of a write with an invalidate strobe and the end of a write with a flush strobe, each carrying a plane bitmask. Only planes named in the per-pipe relevance mask count. Any relevant activity while self-refresh is running raises a one-cycle exit request toward the controller.

Once every relevant plane is clean after a flush, the block starts a re-arm countdown measured in timer ticks. When the countdown ends, it waits a bounded number of ticks for the controller's idle indication. It then raises a one-cycle activate request, unless rendering began again in the meantime. Dropping the enable cancels a pending re-arm. A fresh enable starts with every plane clean.

Top module: `fb_dirty_tracker`

## Requirements
- R1: Plane bits outside `pipeMask` have no effect: they neither set nor clear busy state, cause no exit request and do not count as a hit for scheduling.
- R2: An accepted invalidate sets its masked bits in the busy set. If any masked bit is set and `srActive` is high, `exitReq` is high for exactly the cycle after the strobe.
- R3: An accepted flush clears its masked bits from the busy set. If any masked bit is set and `srActive` is high, `exitReq` is also high in the cycle after the strobe.
- R4: When an invalidate and a flush name the same relevant bit in one cycle, the invalidate wins and the bit stays busy.
- R5: An accepted flush starts a re-arm of `DELAY_TICKS` ticks when no re-arm is pending, the busy set after the update is empty, and either `srActive` is low or the flush carried a masked bit. With `hwIdle` high and a tick every cycle, `activateReq` appears `DELAY_TICKS`+1 cycles after the flush cycle.
- R6: At the moment of the decision, a non-empty busy set suppresses the activation and ends the re-arm.
- R7: After the delay, the block waits for `hwIdle`. If `IDLE_TICKS` ticks pass without it, the re-arm is abandoned and is not retried.
- R8: In the first cycle with `srEnable` high after it was low, the busy set is cleared and strobes in that cycle are ignored.
- R9: While `srEnable` is low, strobes are ignored, and a pending re-arm is cancelled without activation.
- R10: A flush arriving while a re-arm is already pending does not restart its countdown.
- R11: After reset both outputs are low, and `activateReq` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srEnable | input | 1 | Self-refresh enabled on this pipe |
| srActive | input | 1 | Controller currently in self-refresh |
| hwIdle | input | 1 | Controller reports idle and ready to re-arm |
| tick | input | 1 | Timer tick strobe for delay and timeout |
| pipeMask | input | NUM_PLANES | Planes belonging to the self-refresh pipe |
| invValid | input | 1 | Invalidate strobe |
| invBits | input | NUM_PLANES | Planes being dirtied |
| flushValid | input | 1 | Flush strobe |
| flushBits | input | NUM_PLANES | Planes being flushed |
| exitReq | output | 1 | One-cycle request to leave self-refresh |
| activateReq | output | 1 | One-cycle delayed request to re-enter self-refresh |

## Verification
The bench builds the block with eight planes, a pipe mask of 0x0F, a four-tick delay and a three-tick idle timeout. This leaves half the planes irrelevant, so masking is exercised on every strobe. The short windows let countdown expiry, the idle timeout and races between an invalidate and the decision all occur within a few cycles. A random tick pattern also keeps the countdown stalled for arbitrary stretches.

// File: rtl/fbdt_pkg.sv
package fbdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_WAIT  = 2'd2
  } rearmState_e;

  // control -> datapath
  typedef struct packed {
    logic acceptIn;   // strobes may update busy set
    logic clearBusy;  // fresh enable: wipe busy set
    logic loadDelay;  // start re-arm countdown
    logic loadWait;   // start idle timeout
    logic decCount;   // count one tick down
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic busyEmptyNext;  // busy set empty after this cycle's update
    logic flushHit;       // accepted flush carried a relevant bit
    logic cntLast;        // shared counter on its final tick
  } dpStatus_t;

endpackage

// File: rtl/fbdt_datapath.sv
module fbdt_datapath
  import fbdt_pkg::*;
#(
  parameter int NUM_PLANES  = 8,
  parameter int DELAY_TICKS = 100,
  parameter int IDLE_TICKS  = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  srActive,
  input  logic [NUM_PLANES-1:0] pipeMask,
  input  logic                  invValid,
  input  logic [NUM_PLANES-1:0] invBits,
  input  logic                  flushValid,
  input  logic [NUM_PLANES-1:0] flushBits,
  output dpStatus_t             status,
  output logic                  exitReq
);

  localparam int MAX_TICKS = (DELAY_TICKS > IDLE_TICKS) ? DELAY_TICKS : IDLE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [NUM_PLANES-1:0] maskedInv;
  logic [NUM_PLANES-1:0] maskedFlush;
  logic [NUM_PLANES-1:0] busyQ;
  logic [NUM_PLANES-1:0] busyD;
  logic [CNT_W-1:0]      countQ;

  assign maskedInv   = (invValid   && strobe.acceptIn) ? (invBits   & pipeMask) : '0;
  assign maskedFlush = (flushValid && strobe.acceptIn) ? (flushBits & pipeMask) : '0;

  // one busy flop per plane; set beats clear
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    always_comb begin
      if (strobe.clearBusy) busyD[p] = 1'b0;
      else                  busyD[p] = maskedInv[p] | (busyQ[p] & ~maskedFlush[p]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) busyQ[p] <= 1'b0;
      else       busyQ[p] <= busyD[p];
    end
  end

  // shared tick counter for both the re-arm delay and the idle timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countQ <= '0;
    else if (strobe.loadDelay) countQ <= CNT_W'(DELAY_TICKS);
    else if (strobe.loadWait)  countQ <= CNT_W'(IDLE_TICKS);
    else if (strobe.decCount)  countQ <= countQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) exitReq <= 1'b0;
    else       exitReq <= srActive && (|(maskedInv | maskedFlush));
  end

  assign status.busyEmptyNext = ~|busyD;
  assign status.flushHit      = |maskedFlush;
  assign status.cntLast       = (countQ == CNT_W'(1));

endmodule

// File: rtl/fbdt_control.sv
module fbdt_control
  import fbdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srEnable,
  input  logic        srActive,
  input  logic        hwIdle,
  input  logic        tick,
  input  logic        flushValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        activateReq
);

  rearmState_e stateQ, stateD;
  logic        enPrevQ;
  logic        enRise;
  logic        accept;
  logic        actD;

  assign enRise = srEnable && !enPrevQ;
  assign accept = srEnable && enPrevQ;

  always_comb begin
    stateD           = stateQ;
    actD             = 1'b0;
    strobe           = '0;
    strobe.acceptIn  = accept;
    strobe.clearBusy = enRise;

    unique case (stateQ)
      ST_IDLE: begin
        if (accept && flushValid && (!srActive || status.flushHit)
            && status.busyEmptyNext) begin
          stateD           = ST_DELAY;
          strobe.loadDelay = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!srEnable) begin
          stateD = ST_IDLE;
        end else if (tick) begin
          if (status.cntLast) begin
            stateD          = ST_WAIT;
            strobe.loadWait = 1'b1;
          end else begin
            strobe.decCount = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!srEnable) begin
          stateD = ST_IDLE;
        end else if (hwIdle) begin
          actD   = status.busyEmptyNext;
          stateD = ST_IDLE;
        end else if (tick) begin
          if (status.cntLast) stateD = ST_IDLE;
          else                strobe.decCount = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      enPrevQ     <= 1'b0;
      activateReq <= 1'b0;
    end else begin
      stateQ      <= stateD;
      enPrevQ     <= srEnable;
      activateReq <= actD;
    end
  end

endmodule

// File: rtl/fb_dirty_tracker.sv
module fb_dirty_tracker
  import fbdt_pkg::*;
#(
  parameter int NUM_PLANES  = 8,
  parameter int DELAY_TICKS = 100,
  parameter int IDLE_TICKS  = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  srEnable,
  input  logic                  srActive,
  input  logic                  hwIdle,
  input  logic                  tick,
  input  logic [NUM_PLANES-1:0] pipeMask,
  input  logic                  invValid,
  input  logic [NUM_PLANES-1:0] invBits,
  input  logic                  flushValid,
  input  logic [NUM_PLANES-1:0] flushBits,
  output logic                  exitReq,
  output logic                  activateReq
);

  ctrlStrobe_t ctrlStrobe;
  dpStatus_t   dpStatus;

  fbdt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srEnable   (srEnable),
    .srActive   (srActive),
    .hwIdle     (hwIdle),
    .tick       (tick),
    .flushValid (flushValid),
    .status     (dpStatus),
    .strobe     (ctrlStrobe),
    .activateReq(activateReq)
  );

  fbdt_datapath #(
    .NUM_PLANES (NUM_PLANES),
    .DELAY_TICKS(DELAY_TICKS),
    .IDLE_TICKS (IDLE_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctrlStrobe),
    .srActive  (srActive),
    .pipeMask  (pipeMask),
    .invValid  (invValid),
    .invBits   (invBits),
    .flushValid(flushValid),
    .flushBits (flushBits),
    .status    (dpStatus),
    .exitReq   (exitReq)
  );

endmodule

// File: rtl/fbdt_checker.sv
module fbdt_checker #(
  parameter int NUM_PLANES = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  srEnable,
  input logic                  srActive,
  input logic                  hwIdle,
  input logic [NUM_PLANES-1:0] pipeMask,
  input logic                  invValid,
  input logic [NUM_PLANES-1:0] invBits,
  input logic                  flushValid,
  input logic [NUM_PLANES-1:0] flushBits,
  input logic                  exitReq,
  input logic                  activateReq
);

  AST_NO_EXIT_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!(invValid && |(invBits & pipeMask)) && !(flushValid && |(flushBits & pipeMask)))
      |=> !exitReq); // R1

  AST_EXIT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |-> $past(srActive)); // R2

  AST_ACT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    activateReq |-> $past(hwIdle)); // R7

  AST_ACT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    activateReq |-> $past(srEnable)); // R9

  AST_ENABLE_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srEnable) |=> !exitReq); // R8

  AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    activateReq |=> !activateReq); // R11

endmodule

bind fb_dirty_tracker fbdt_checker #(.NUM_PLANES(NUM_PLANES)) u_chk (.*);

// File: tb/sim_fb_dirty_tracker.sv
`timescale 1ns/1ps
module sim_fb_dirty_tracker;

  localparam int NP = 8;
  localparam int DT = 4;
  localparam int IT = 3;

  logic clk = 1'b0;
  logic rstN;
  logic srEnable, srActive, hwIdle, tick;
  logic [NP-1:0] pipeMask, invBits, flushBits;
  logic invValid, flushValid;
  logic exitReq, activateReq;

  always #2.5 clk = ~clk;

  fb_dirty_tracker #(.NUM_PLANES(NP), .DELAY_TICKS(DT), .IDLE_TICKS(IT)) u0 (
    .clk(clk), .rstN(rstN), .srEnable(srEnable), .srActive(srActive),
    .hwIdle(hwIdle), .tick(tick), .pipeMask(pipeMask),
    .invValid(invValid), .invBits(invBits),
    .flushValid(flushValid), .flushBits(flushBits),
    .exitReq(exitReq), .activateReq(activateReq));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [NP-1:0] mBusy;
  int            mState;
  int            mCnt;
  logic          mEnPrev;
  logic          expExit, expAct;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // next model state from the inputs currently driven
  task automatic modelStep();
    logic enRise, accept;
    logic [NP-1:0] mi, mf, nb;
    enRise = srEnable && !mEnPrev;
    accept = srEnable && mEnPrev;
    mi = (invValid && accept) ? (invBits & pipeMask) : '0;
    mf = (flushValid && accept) ? (flushBits & pipeMask) : '0;
    nb = enRise ? '0 : ((mBusy & ~mf) | mi);
    expExit = srActive && ((mi | mf) != '0);
    expAct  = 1'b0;
    case (mState)
      0: if (accept && flushValid && (!srActive || mf != '0) && nb == '0) begin
           mState = 1; mCnt = DT;
         end
      1: if (!srEnable) mState = 0;
         else if (tick) begin
           if (mCnt == 1) begin mState = 2; mCnt = IT; end
           else mCnt--;
         end
      default: if (!srEnable) mState = 0;
         else if (hwIdle) begin expAct = (nb == '0); mState = 0; end
         else if (tick) begin
           if (mCnt == 1) mState = 0;
           else mCnt--;
         end
    endcase
    mBusy   = nb;
    mEnPrev = srEnable;
  endtask

  // one clock; strobes are cleared afterwards
  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk(exitReq == expExit, "R2/R3 exitReq vs model", exitReq, expExit);
    chk(activateReq == expAct, "R5/R6 activateReq vs model", activateReq, expAct);
    invValid = 0; flushValid = 0; invBits = '0; flushBits = '0;
  endtask

  task automatic countActs(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (activateReq) cnt++;
    end
  endtask

  task automatic doInv(input logic [NP-1:0] b);
    invValid = 1; invBits = b; cyc();
  endtask

  task automatic doFlush(input logic [NP-1:0] b);
    flushValid = 1; flushBits = b; cyc();
  endtask

  initial begin
    int n;
    int when;
    void'($urandom(32'h5EED_1234));
    rstN = 0; srEnable = 0; srActive = 0; hwIdle = 0; tick = 0;
    pipeMask = 8'h0F; invValid = 0; invBits = '0; flushValid = 0; flushBits = '0;
    mBusy = '0; mState = 0; mCnt = 0; mEnPrev = 0; expExit = 0; expAct = 0;
    repeat (3) @(negedge clk);
    chk(exitReq == 0, "R11 reset exitReq", exitReq, 0);
    chk(activateReq == 0, "R11 reset activateReq", activateReq, 0);
    rstN = 1;
    srEnable = 1; srActive = 1; tick = 1;
    repeat (3) cyc();

    // R1: irrelevant planes do nothing
    invValid = 1; invBits = 8'hF0; cyc();
    chk(exitReq == 0, "R1 unmasked invalidate no exit", exitReq, 0);
    flushValid = 1; flushBits = 8'hF0; cyc();
    countActs(20, n);
    chk(n == 0, "R1 unmasked flush no re-arm", n, 0);

    // R2: invalidate while active
    doInv(8'h01);
    chk(exitReq == 1, "R2 invalidate exit pulse", exitReq, 1);
    cyc();
    chk(exitReq == 0, "R2 exit pulse one cycle", exitReq, 0);

    // R4: same-cycle invalidate and flush on bit 1
    srActive = 0; hwIdle = 1;
    invValid = 1; invBits = 8'h02; flushValid = 1; flushBits = 8'h03; cyc();
    countActs(20, n);
    chk(n == 0, "R4 invalidate wins, bit stays busy", n, 0);

    // R3: flush clears the remaining bit, exit requested while active
    srActive = 1;
    doFlush(8'h02);
    chk(exitReq == 1, "R3 flush exit pulse", exitReq, 1);
    srActive = 0;
    countActs(20, n);
    chk(n == 1, "R3/R5 flush clears busy then re-arm", n, 1);

    // R5 + R10: latency and no restart
    doFlush(8'h00);
    when = -1;
    for (int k = 1; k <= 12; k++) begin
      if (k == 2) begin flushValid = 1; flushBits = 8'h00; end
      cyc();
      if (activateReq && when < 0) when = k;
    end
    chk(when == DT + 1, "R5 R10 activation latency", when, DT + 1);

    // R6: invalidate during countdown blocks activation
    doFlush(8'h00);
    doInv(8'h04);
    countActs(20, n);
    chk(n == 0, "R6 busy at decision suppresses", n, 0);
    doFlush(8'h04);
    countActs(20, n);
    chk(n == 1, "R6 later flush re-arms", n, 1);

    // R7: idle timeout abandons without retry
    hwIdle = 0;
    doFlush(8'h00);
    countActs(20, n);
    hwIdle = 1;
    countActs(20, n);
    chk(n == 0, "R7 timeout abandons re-arm", n, 0);

    // R9: disable cancels pending re-arm
    doFlush(8'h00);
    cyc();
    srEnable = 0; cyc();
    srEnable = 1;
    countActs(20, n);
    chk(n == 0, "R9 disable cancels re-arm", n, 0);

    // R8: busy cleared on fresh enable; strobes ignored while off and on the edge
    doInv(8'h08);
    srEnable = 0;
    invValid = 1; invBits = 8'h01; cyc();
    srEnable = 1;
    invValid = 1; invBits = 8'h02; cyc();
    chk(exitReq == 0, "R8 enable edge strobe ignored", exitReq, 0);
    doFlush(8'h00);
    countActs(20, n);
    chk(n == 1, "R8 busy cleared by enable", n, 1);

    // constrained random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      srEnable   = ($urandom_range(0, 99) < 97);
      srActive   = ($urandom_range(0, 99) < 30);
      hwIdle     = ($urandom_range(0, 99) < 60);
      tick       = ($urandom_range(0, 99) < 50);
      invValid   = ($urandom_range(0, 99) < 8);
      invBits    = NP'($urandom);
      flushValid = ($urandom_range(0, 99) < 15);
      flushBits  = NP'($urandom);
      if (i % 500 == 0) pipeMask = NP'($urandom);
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule